// File: doc/BRIEF.md
# Frame-Sync Slave Output Serializer

This block is the output stage of a converter in frame-synchronised slave operation. A host drives a frame strobe and a bit clock. The block has no clock of its own on the serial side: it oversamples both lines with its master clock and reacts to their edges. A frame lasts 32 bit-clock periods. The frame strobe is high for the first half of the frame and low for the second half.

A converted result of 24 bits arrives on a parallel bus with a one-cycle valid strobe. It is parked in a holding register and moves into the output shift register only when the frame strobe rises. The most significant bit then appears on the serial output at once. Each falling edge of the bit clock moves the output on by one bit. The shift register is 24 bits long. It fills from the daisy-chain input, which is sampled on rising bit-clock edges. As a result, data from a downstream device follows the local word directly, and a chain of devices can share one data line. With the daisy input tied low, the last 8 bits of the frame are zeros.

If the frame strobe rises again before exactly 32 falling bit-clock edges have been counted, or after more than 32, the block raises a frame-error flag.

Top module: `fs_slave_serializer`

## Requirements
- R1: While reset is high, and until the first frame starts, `dout` and `frame_err` are 0. The holding register resets to zero.
- R2: On a rising edge of `fsync`, the held word is loaded, and its bit 23 appears on `dout` before any falling edge of `sclk`.
- R3: Each falling edge of `sclk` moves `dout` on by one bit. Bit index j of the frame, for j from 0 to 23, is word bit 23-j.
- R4: Frame bit 24+k, for k from 0 to 7, equals the value `daisy_in` had at the rising `sclk` edge inside bit period k. With `daisy_in` low, these bits are 0. With a second device chained into `daisy_in`, they are that device's bits 23 down to 16.
- R5: `sample_valid` copies `sample_data` into the holding register. The output word changes only at a rising edge of `fsync`. A sample that arrives mid-frame does not touch the current frame and is sent in the next frame. A frame with no new sample repeats the previous word.
- R6: On each rising edge of `fsync` after the first, `frame_err` becomes 1 if the count of falling `sclk` edges since the previous rise was not exactly 32, and 0 otherwise. It holds its value between rises, and the first rise after reset never sets it.
- R7: After 32 falling `sclk` edges in a frame, further falling edges do not shift. `dout` keeps the bit it showed after the 32nd edge until the next rise of `fsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock that samples every input |
| rst | input | 1 | Synchronous reset, active high |
| fsync | input | 1 | Frame strobe from the host, high for the first half of the frame |
| sclk | input | 1 | Bit clock from the host, 32 periods per frame |
| daisy_in | input | 1 | Serial data from the next device down the chain |
| sample_data | input | 24 | Parallel conversion result |
| sample_valid | input | 1 | One-cycle strobe that marks a new result |
| dout | output | 1 | Serial data, MSB first |
| frame_err | output | 1 | Last frame did not contain exactly 32 falling bit-clock edges |

## Verification
The assertions assume that `fsync` and `sclk` each stay at one level for several master-clock cycles. They also assume that a rise of `fsync` never falls in the same sampled cycle as a falling edge of `sclk`, and that `daisy_in` is steady around the rising bit-clock edge. The stimulus keeps to these limits by building every bit period from 8 master-clock cycles: `sclk` is high in cycles 2 to 5, and the daisy bit and the `fsync` level change only in cycle 0. `sample_valid` is pulsed either between frames or in the middle of bit period 10, well clear of any strobe edge. Short and long frames are built by changing only the number of bit periods, so the edge spacing stays the same.

// File: rtl/fss_pkg.sv
package fss_pkg;

    localparam int WORD_W_DEF    = 24;
    localparam int FRAME_LEN_DEF = 32;
    localparam int SYNC_DEF      = 2;

    // Two most recent sampled levels of a host-driven line
    typedef struct packed {
        logic now;
        logic prev;
    } pin_hist_t;

    function automatic logic is_rise(pin_hist_t h);
        return h.now & ~h.prev;
    endfunction

    function automatic logic is_fall(pin_hist_t h);
        return ~h.now & h.prev;
    endfunction

    // Counter width able to hold FRAME_LEN + 1 (saturation value)
    function automatic int cnt_width(int frame_len);
        return $clog2(frame_len + 2);
    endfunction

endpackage

// File: rtl/fss_pin_sampler.sv
module fss_pin_sampler
    import fss_pkg::*;
#(
    parameter int STAGES = SYNC_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      raw,
    output pin_hist_t hist
);
    // STAGES sampling flops plus one history flop
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= raw;
            for (int i = 1; i <= STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign hist.now  = pipe[STAGES-1];
    assign hist.prev = pipe[STAGES];

endmodule

// File: rtl/fss_sample_hold.sv
module fss_sample_hold #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (valid) begin
            held <= data;
        end
    end

    AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        valid |=> held == $past(data)); // R5
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(held)); // R5

endmodule

// File: rtl/fss_shifter.sv
module fss_shifter
    import fss_pkg::*;
#(
    parameter int WORD_W    = WORD_W_DEF,
    parameter int FRAME_LEN = FRAME_LEN_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_hist_t         fs_h,
    input  pin_hist_t         sc_h,
    input  logic              daisy_in,
    input  logic [WORD_W-1:0] load_word,
    output logic              dout,
    output logic              frame_err
);
    localparam int             CW      = cnt_width(FRAME_LEN);
    localparam logic [CW-1:0]  FULL_C  = CW'(FRAME_LEN);
    localparam logic [CW-1:0]  SAT_C   = CW'(FRAME_LEN + 1);

    logic [WORD_W-1:0] shreg;
    logic [CW-1:0]     cnt;
    logic              daisy_q;
    logic              started;
    logic              fs_rise, sc_rise, sc_fall, shift_ok;

    assign fs_rise  = is_rise(fs_h);
    assign sc_rise  = is_rise(sc_h);
    assign sc_fall  = is_fall(sc_h);
    assign shift_ok = (cnt < FULL_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            cnt       <= '0;
            daisy_q   <= 1'b0;
            started   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            if (sc_rise) begin
                daisy_q <= daisy_in;
            end
            if (fs_rise) begin
                shreg     <= load_word;
                cnt       <= '0;
                started   <= 1'b1;
                frame_err <= started && (cnt != FULL_C);
            end else if (sc_fall) begin
                if (shift_ok) begin
                    shreg <= {shreg[WORD_W-2:0], daisy_q};
                end
                if (cnt != SAT_C) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign dout = shreg[WORD_W-1];

    AST_MSB_LOAD: assert property (@(posedge clk) disable iff (rst)
        fs_rise |=> dout == $past(load_word[WORD_W-1])); // R2
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        (sc_fall && !fs_rise && shift_ok) |=> dout == $past(shreg[WORD_W-2])); // R3
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!fs_rise && !(sc_fall && shift_ok)) |=> $stable(dout)); // R7
    AST_SAT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!fs_rise && !shift_ok) |=> $stable(shreg)); // R7
    AST_ERR_STEADY: assert property (@(posedge clk) disable iff (rst)
        !fs_rise |=> $stable(frame_err)); // R6
    AST_FIRST_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (fs_rise && !started) |=> !frame_err); // R6
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= SAT_C); // R6

endmodule

// File: rtl/fs_slave_serializer.sv
module fs_slave_serializer
    import fss_pkg::*;
#(
    parameter int WORD_W      = WORD_W_DEF,
    parameter int FRAME_LEN   = FRAME_LEN_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fsync,
    input  logic              sclk,
    input  logic              daisy_in,
    input  logic [WORD_W-1:0] sample_data,
    input  logic              sample_valid,
    output logic              dout,
    output logic              frame_err
);
    localparam int N_PINS = 2;   // index 0: frame strobe, 1: bit clock

    logic      [N_PINS-1:0] raw_pins;
    pin_hist_t              hist [N_PINS];
    logic      [WORD_W-1:0] held_word;

    assign raw_pins = {sclk, fsync};

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        fss_pin_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_pins[g]),
            .hist (hist[g])
        );
    end

    fss_sample_hold #(.WORD_W(WORD_W)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .valid (sample_valid),
        .data  (sample_data),
        .held  (held_word)
    );

    fss_shifter #(.WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .fs_h      (hist[0]),
        .sc_h      (hist[1]),
        .daisy_in  (daisy_in),
        .load_word (held_word),
        .dout      (dout),
        .frame_err (frame_err)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!dout && !frame_err)); // R1

endmodule

// File: tb/fs_slave_serializer_bench.sv
module fs_slave_serializer_bench;

    localparam int W = 24;
    localparam int F = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         fsync, sclk;
    logic         bench_daisy, chain_sel;
    logic [W-1:0] near_data, far_data;
    logic         near_valid, far_valid;
    logic         near_dout, far_dout, near_err, far_err;
    logic         near_daisy;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] near_hold, far_hold;   // bench models of the holding registers
    logic [0:63]  dpat;
    int           frames_done;
    int           prev_slots;

    always #4 clk = ~clk;

    assign near_daisy = chain_sel ? far_dout : bench_daisy;

    fs_slave_serializer u_fs_slave_serializer (
        .clk(clk), .rst(rst), .fsync(fsync), .sclk(sclk),
        .daisy_in(near_daisy), .sample_data(near_data),
        .sample_valid(near_valid), .dout(near_dout), .frame_err(near_err)
    );

    fs_slave_serializer u_far (
        .clk(clk), .rst(rst), .fsync(fsync), .sclk(sclk),
        .daisy_in(1'b0), .sample_data(far_data),
        .sample_valid(far_valid), .dout(far_dout), .frame_err(far_err)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected bit j of a frame; past the frame length the output is frozen (R7)
    function automatic logic exp_bit(int j, logic [W-1:0] w, logic [0:63] dp);
        int k;
        k = (j > F) ? F : j;
        if (k < W) return w[W-1-k];
        return dp[k-W];
    endfunction

    task automatic pulse_sample(input bit to_far, input logic [W-1:0] w);
        @(negedge clk);
        if (to_far) begin far_data = w; far_valid = 1'b1; end
        else        begin near_data = w; near_valid = 1'b1; end
        @(negedge clk);
        far_valid  = 1'b0;
        near_valid = 1'b0;
        if (to_far) far_hold = w; else near_hold = w;
    endtask

    task automatic do_frame(input int nslots, input bit mid_en,
                            input logic [W-1:0] mid_w, input string tag);
        logic [W-1:0] exp_w;
        logic [0:63]  dp_eff;
        logic [0:63]  got;
        bit           exp_err;
        string        rq;
        exp_w = near_hold;
        got   = '0;
        if (chain_sel) begin
            for (int k = 0; k < 64; k++) dp_eff[k] = (k < W) ? far_hold[W-1-k] : 1'b0;
        end else begin
            dp_eff = dpat;
        end
        for (int s = 0; s < nslots; s++) begin
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                fsync = ((s * 8 + c) < nslots * 4);
                sclk  = (c >= 2 && c <= 5);
                if (c == 0) bench_daisy = dpat[s];
                if (mid_en && s == 10 && c == 1) begin
                    near_data  = mid_w;
                    near_valid = 1'b1;
                end
                if (mid_en && s == 10 && c == 2) begin
                    near_valid = 1'b0;
                    near_hold  = mid_w;
                end
                if (c == 4) begin
                    got[s] = near_dout;
                    if (s == 0) begin
                        exp_err = (frames_done > 0) && (prev_slots != F);
                        check(near_err == exp_err, "R6 frame_err", 32'(near_err), 32'(exp_err));
                    end
                end
            end
        end
        for (int j = 0; j < nslots; j++) begin
            if (tag != "" && j < W) rq = tag;
            else if (j == 0)        rq = "R2 msb";
            else if (j < W)         rq = "R3 word bit";
            else if (j < F)         rq = "R4 daisy bit";
            else                    rq = "R7 frozen bit";
            check(got[j] == exp_bit(j, exp_w, dp_eff), rq,
                  32'(got[j]), 32'(exp_bit(j, exp_w, dp_eff)));
        end
        prev_slots = nslots;
        frames_done++;
    endtask

    task automatic rand_dpat();
        for (int k = 0; k < 64; k++) dpat[k] = 1'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        rst = 1'b1; fsync = 1'b0; sclk = 1'b0; bench_daisy = 1'b0; chain_sel = 1'b0;
        near_data = '0; far_data = '0; near_valid = 1'b0; far_valid = 1'b0;
        near_hold = '0; far_hold = '0; dpat = '0; frames_done = 0; prev_slots = F;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(near_dout == 1'b0, "R1 dout in reset", 32'(near_dout), 32'd0);
        check(near_err == 1'b0, "R1 frame_err in reset", 32'(near_err), 32'd0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check(near_dout == 1'b0, "R1 dout idle", 32'(near_dout), 32'd0);
        check(near_err == 1'b0, "R1 frame_err idle", 32'(near_err), 32'd0);

        // R1: reset-value word, zero padding (R4)
        do_frame(F, 1'b0, '0, "R1 reset word");

        // directed words, daisy low
        pulse_sample(1'b0, 24'hA5C3F1);
        do_frame(F, 1'b0, '0, "");
        pulse_sample(1'b0, 24'hFFFFFF);
        do_frame(F, 1'b0, '0, "");
        pulse_sample(1'b0, 24'h800001);
        do_frame(F, 1'b0, '0, "");

        // R5: no new sample repeats the word
        do_frame(F, 1'b0, '0, "R5 repeat word");

        // R5: two samples, last one wins
        pulse_sample(1'b0, 24'h123456);
        pulse_sample(1'b0, 24'h0F0F0F);
        do_frame(F, 1'b0, '0, "R5 last sample");

        // R5: mid-frame sample waits for the next frame
        do_frame(F, 1'b1, 24'h5A5A5A, "R5 mid-frame untouched");
        do_frame(F, 1'b0, '0, "R5 mid-frame next");

        // R4: chained device, directed
        chain_sel = 1'b1;
        pulse_sample(1'b1, 24'hC30000);
        pulse_sample(1'b0, 24'h00FF00);
        do_frame(F, 1'b0, '0, "");

        // random frames
        for (int n = 0; n < 16; n++) begin
            chain_sel = 1'($urandom);
            rand_dpat();
            if ($urandom % 4 != 0) pulse_sample(1'b0, W'($urandom));
            if ($urandom % 2 != 0) pulse_sample(1'b1, W'($urandom));
            do_frame(F, 1'b0, '0, "");
        end

        // R6: short frame, then error flagged, then cleared
        chain_sel = 1'b0;
        rand_dpat();
        do_frame(20, 1'b0, '0, "");
        do_frame(F, 1'b0, '0, "");
        do_frame(F, 1'b0, '0, "");

        // R7: long frame, extra falling edges do not shift; flagged after
        rand_dpat();
        pulse_sample(1'b0, 24'h3C3C3C);
        do_frame(34, 1'b0, '0, "");
        do_frame(F, 1'b0, '0, "");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule